// File: doc/BRIEF.md
# Run-Time Selectable Gate Package Emulator

This block lets one piece of programmable logic stand in for a handful of small discrete gate packages. It has four sockets. Each socket receives a 5-bit identity code that names the kind of package plugged into it. Each socket also has 14 package pin positions. The socket drives the output pins of the selected package from its input pins, using the usual pin pairing for that package family. External wiring, outside this block, joins the socket pins to switch levels and to one another. This is how small combinational exercises, such as a full subtractor, are assembled.

Each identity code is captured in a register on the clock, so a new package takes over one cycle after its code is presented. From a socket's input pins to its output pins the path contains only gates. Every gate output is also copied to an indicator bus of 32 lights: eight per socket, where a lit light means logic 1. A code outside the supported set, or the reset state, makes the socket behave as an empty slot that drives nothing.

Top module: `gate_socket_array`

## Requirements
- R1: The four sockets are independent. Socket s takes its code from `sock_code[5s+4:5s]`, its pin p input from `pin_in[14s+p-1]`, and drives `pin_out`, `pin_drv` at the same bit positions. A code on one socket never changes another socket's outputs.
- R2: A code is captured at a rising clock edge and governs the socket from that edge on. Before the edge, the previous code still applies. A change on `pin_in` reaches `pin_out` with no clock edge in between.
- R3: While reset is held, and until a code is first captured after reset, every socket is empty: all of `pin_out`, `pin_drv` and `led` are 0.
- R4: Any code of 16 or above (bit 4 set) marks the socket empty. Its `pin_out`, `pin_drv` and its eight `led` bits are all 0, whatever its pin inputs are.
- R5: Code 4 selects four 2-input AND gates. The 16 supported codes are: 0 NAND2, 1 NOR2, 2 inverter, 3 NAND3, 4 AND2, 5 NAND4, 6 NAND8, 7 OR2, 8 XOR2, 9 XNOR2, 10 buffer, 11 AND3, 12 NOR3, 13 OR3, 14 AND4, 15 NOR4.
- R6: The pin groups for each family are listed below as (inputs)->output, in gate order 0, 1, 2 and so on.
  - 2-input packages other than NOR2: (1,2)->3, (4,5)->6, (9,10)->8, (12,13)->11.
  - NOR2: (2,3)->1, (5,6)->4, (8,9)->10, (11,12)->13.
  - Inverter and buffer: 1->2, 3->4, 5->6, 9->8, 11->10, 13->12.
  - 3-input packages: (1,2,13)->12, (3,4,5)->6, (9,10,11)->8.
  - 4-input packages: (1,2,4,5)->6, (9,10,12,13)->8.
  - NAND8: (1,2,3,4,5,6,11,12)->8.
- R7: `pin_drv` is 1 exactly on the output pins of the selected package. `pin_out` is 0 on every pin that is not driven. Pins 7 and 14 are never driven, and their input levels have no effect.
- R8: `led[8s+g]` shows the output of gate g of socket s in the R6 order. Indicator bits of gates the package does not have are 0.
- R9: Four sockets set to XOR2, AND2, inverter and OR2 can be wired externally into a full subtractor. For every input (Bi,A,B) the result matches D = Bi^A^B and Bo = (~A&B)|(Bi&~(A^B)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the code registers |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sock_code | input | 20 | Identity code per socket, 5 bits each |
| pin_in | input | 56 | Levels present on the socket pins, 14 per socket |
| pin_out | output | 56 | Levels the sockets drive onto their output pins |
| pin_drv | output | 56 | Marks which socket pins are package outputs |
| led | output | 32 | Indicator lights, eight per socket, one per gate |

## Verification
The clocked properties sample `pin_in` and `pin_out` together at the clock edge. They therefore assume the pin levels, including any external feedback wiring through other sockets, have settled before each edge. They also assume the code seen at one edge is the one captured at the previous edge, which holds only once the internal reset release has passed. The stimulus changes pins and codes only between edges. It lets the subtractor's feedback loop settle in several short steps inside one clock period, and it waits out the reset synchronizer before presenting any code that matters.

// File: rtl/gsa_pkg.sv
package gsa_pkg;

  localparam int PINS  = 14;
  localparam int GATES = 6;

  typedef enum logic [2:0] {
    LY_NONE, LY_QUAD, LY_QNOR, LY_HEX, LY_TRI, LY_DUAL, LY_OCT
  } layout_e;

  typedef enum logic [1:0] {FN_AND, FN_OR, FN_XOR} gfn_e;

  typedef struct packed {
    layout_e lay;
    gfn_e    fn;
    logic    inv;
  } sock_cfg_t;

endpackage

// File: rtl/gsa_code_reg.sv
module gsa_code_reg #(
  parameter int N_SOCK = 4,
  parameter int CODE_W = 5,
  parameter logic [CODE_W-1:0] RST_CODE = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SOCK*CODE_W-1:0] code_in,
  output logic [N_SOCK*CODE_W-1:0] code_q
);

  for (genvar s = 0; s < N_SOCK; s++) begin : g_slot
    logic              ld;
    logic [CODE_W-1:0] nxt;
    logic [CODE_W-1:0] cur;

    always_comb begin
      nxt = code_in[s*CODE_W +: CODE_W];
      ld  = (nxt != cur);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur <= RST_CODE;
      end else if (ld) begin
        cur <= nxt;
      end
    end

    assign code_q[s*CODE_W +: CODE_W] = cur;
  end

endmodule

// File: rtl/gsa_code_decode.sv
module gsa_code_decode
  import gsa_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0] code,
  output sock_cfg_t         cfg
);

  logic known;
  assign known = (code[CODE_W-1:4] == '0);

  always_comb begin
    cfg = '{LY_NONE, FN_AND, 1'b0};
    if (known) begin
      case (code[3:0])
        4'd0:  cfg = '{LY_QUAD, FN_AND, 1'b1};
        4'd1:  cfg = '{LY_QNOR, FN_OR,  1'b1};
        4'd2:  cfg = '{LY_HEX,  FN_AND, 1'b1};
        4'd3:  cfg = '{LY_TRI,  FN_AND, 1'b1};
        4'd4:  cfg = '{LY_QUAD, FN_AND, 1'b0};
        4'd5:  cfg = '{LY_DUAL, FN_AND, 1'b1};
        4'd6:  cfg = '{LY_OCT,  FN_AND, 1'b1};
        4'd7:  cfg = '{LY_QUAD, FN_OR,  1'b0};
        4'd8:  cfg = '{LY_QUAD, FN_XOR, 1'b0};
        4'd9:  cfg = '{LY_QUAD, FN_XOR, 1'b1};
        4'd10: cfg = '{LY_HEX,  FN_AND, 1'b0};
        4'd11: cfg = '{LY_TRI,  FN_AND, 1'b0};
        4'd12: cfg = '{LY_TRI,  FN_OR,  1'b1};
        4'd13: cfg = '{LY_TRI,  FN_OR,  1'b0};
        4'd14: cfg = '{LY_DUAL, FN_AND, 1'b0};
        default: cfg = '{LY_DUAL, FN_OR, 1'b1};
      endcase
    end
  end

endmodule

// File: rtl/gsa_socket.sv
module gsa_socket
  import gsa_pkg::*;
(
  input  sock_cfg_t        cfg,
  input  logic [PINS-1:0]  pin_in,
  output logic [PINS-1:0]  pin_out,
  output logic [PINS-1:0]  pin_drv,
  output logic [GATES-1:0] gate_q
);

  logic [PINS-1:0] gmask [GATES];
  logic [3:0]      gidx  [GATES];
  logic [GATES-1:0] gon;

  function automatic logic [PINS-1:0] pb(input int p);
    return PINS'(1) << (p - 1);
  endfunction

  function automatic logic [3:0] ix(input int p);
    return 4'(p - 1);
  endfunction

  always_comb begin
    for (int g = 0; g < GATES; g++) begin
      gmask[g] = '0;
      gidx[g]  = '0;
    end
    case (cfg.lay)
      LY_QUAD: begin
        gmask[0] = pb(1) | pb(2);   gidx[0] = ix(3);
        gmask[1] = pb(4) | pb(5);   gidx[1] = ix(6);
        gmask[2] = pb(9) | pb(10);  gidx[2] = ix(8);
        gmask[3] = pb(12) | pb(13); gidx[3] = ix(11);
      end
      LY_QNOR: begin
        gmask[0] = pb(2) | pb(3);   gidx[0] = ix(1);
        gmask[1] = pb(5) | pb(6);   gidx[1] = ix(4);
        gmask[2] = pb(8) | pb(9);   gidx[2] = ix(10);
        gmask[3] = pb(11) | pb(12); gidx[3] = ix(13);
      end
      LY_HEX: begin
        gmask[0] = pb(1);  gidx[0] = ix(2);
        gmask[1] = pb(3);  gidx[1] = ix(4);
        gmask[2] = pb(5);  gidx[2] = ix(6);
        gmask[3] = pb(9);  gidx[3] = ix(8);
        gmask[4] = pb(11); gidx[4] = ix(10);
        gmask[5] = pb(13); gidx[5] = ix(12);
      end
      LY_TRI: begin
        gmask[0] = pb(1) | pb(2) | pb(13);  gidx[0] = ix(12);
        gmask[1] = pb(3) | pb(4) | pb(5);   gidx[1] = ix(6);
        gmask[2] = pb(9) | pb(10) | pb(11); gidx[2] = ix(8);
      end
      LY_DUAL: begin
        gmask[0] = pb(1) | pb(2) | pb(4) | pb(5);    gidx[0] = ix(6);
        gmask[1] = pb(9) | pb(10) | pb(12) | pb(13); gidx[1] = ix(8);
      end
      LY_OCT: begin
        gmask[0] = pb(1) | pb(2) | pb(3) | pb(4) | pb(5) | pb(6)
                 | pb(11) | pb(12);
        gidx[0]  = ix(8);
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < GATES; g++) begin : g_gate
    logic r;
    always_comb begin
      case (cfg.fn)
        FN_AND:  r = &(pin_in | ~gmask[g]);
        FN_OR:   r = |(pin_in & gmask[g]);
        default: r = ^(pin_in & gmask[g]);
      endcase
    end
    assign gon[g]    = |gmask[g];
    assign gate_q[g] = gon[g] & (r ^ cfg.inv);
  end

  always_comb begin
    pin_out = '0;
    pin_drv = '0;
    for (int g = 0; g < GATES; g++) begin
      if (gon[g]) begin
        pin_out[gidx[g]] = gate_q[g];
        pin_drv[gidx[g]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/gate_socket_array.sv
module gate_socket_array
  import gsa_pkg::*;
#(
  parameter int N_SOCK = 4,
  parameter int CODE_W = 5,
  parameter int N_LED  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_SOCK*CODE_W-1:0] sock_code,
  input  logic [N_SOCK*PINS-1:0]   pin_in,
  output logic [N_SOCK*PINS-1:0]   pin_out,
  output logic [N_SOCK*PINS-1:0]   pin_drv,
  output logic [N_LED-1:0]         led
);

  localparam int LED_PER = N_LED / N_SOCK;
  localparam logic [CODE_W-1:0] EMPTY_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [N_SOCK*CODE_W-1:0] code_q;

  gsa_code_reg #(
    .N_SOCK   (N_SOCK),
    .CODE_W   (CODE_W),
    .RST_CODE (EMPTY_CODE)
  ) u_code_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .code_in (sock_code),
    .code_q  (code_q)
  );

  for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
    sock_cfg_t        cfg;
    logic [GATES-1:0] gq;

    gsa_code_decode #(.CODE_W(CODE_W)) u_dec (
      .code (code_q[s*CODE_W +: CODE_W]),
      .cfg  (cfg)
    );

    gsa_socket u_sock (
      .cfg     (cfg),
      .pin_in  (pin_in[s*PINS +: PINS]),
      .pin_out (pin_out[s*PINS +: PINS]),
      .pin_drv (pin_drv[s*PINS +: PINS]),
      .gate_q  (gq)
    );

    assign led[s*LED_PER +: LED_PER] = LED_PER'(gq);
  end

endmodule

// File: rtl/gsa_checker.sv
module gsa_checker
  import gsa_pkg::*;
#(
  parameter int N_SOCK = 4,
  parameter int CODE_W = 5,
  parameter int N_LED  = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_SOCK*CODE_W-1:0] sock_code,
  input logic [N_SOCK*PINS-1:0]   pin_in,
  input logic [N_SOCK*PINS-1:0]   pin_out,
  input logic [N_SOCK*PINS-1:0]   pin_drv,
  input logic [N_LED-1:0]         led
);

  localparam int LED_PER = N_LED / N_SOCK;

  for (genvar s = 0; s < N_SOCK; s++) begin : g_chk
    // R4
    empty_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sock_code[s*CODE_W + CODE_W - 1]))
      |-> (pin_out[s*PINS +: PINS] == '0 && pin_drv[s*PINS +: PINS] == '0
           && led[s*LED_PER +: LED_PER] == '0));

    // R5
    and_fn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sock_code[s*CODE_W +: CODE_W]) == CODE_W'(4))
      |-> (pin_out[s*PINS + 2] == (pin_in[s*PINS] & pin_in[s*PINS + 1])));

    // R7
    supply_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_drv[s*PINS + 6] == 1'b0 && pin_drv[s*PINS + 13] == 1'b0));

    // R7
    drv_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out[s*PINS +: PINS] & ~pin_drv[s*PINS +: PINS]) == '0));

    // R2
    drv_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sock_code[s*CODE_W +: CODE_W] == $past(sock_code[s*CODE_W +: CODE_W]))
      |=> $stable(pin_drv[s*PINS +: PINS]));
  end

endmodule

bind gate_socket_array gsa_checker #(
  .N_SOCK (N_SOCK),
  .CODE_W (CODE_W),
  .N_LED  (N_LED)
) u_gsa_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sock_code (sock_code),
  .pin_in    (pin_in),
  .pin_out   (pin_out),
  .pin_drv   (pin_drv),
  .led       (led)
);

// File: tb/tb_gate_socket_array.sv
`timescale 1ns/100ps
module tb_gate_socket_array;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] sock_code;
  logic [55:0] pin_in;
  logic [55:0] pin_out;
  logic [55:0] pin_drv;
  logic [31:0] led;

  int checks = 0;
  int errors = 0;
  logic [4:0] cur [4];

  always #2.5 clk = ~clk;

  gate_socket_array dut (
    .clk(clk), .rst_n(rst_n), .sock_code(sock_code),
    .pin_in(pin_in), .pin_out(pin_out), .pin_drv(pin_drv), .led(led)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #950000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  // Behavioural reference: package kind and pin groups from R5/R6.
  task automatic model(input logic [4:0] code, input logic [13:0] p,
                       output logic [13:0] o, output logic [13:0] d,
                       output logic [7:0] l);
    int lay, kind; bit neg; bit acc;
    int gi [6][8]; int go [6];
    o = '0; d = '0; l = '0;
    if (code > 5'd15) return;
    case (code)
      5'd0:  begin lay = 1; kind = 0; neg = 1; end
      5'd1:  begin lay = 2; kind = 1; neg = 1; end
      5'd2:  begin lay = 3; kind = 0; neg = 1; end
      5'd3:  begin lay = 4; kind = 0; neg = 1; end
      5'd4:  begin lay = 1; kind = 0; neg = 0; end
      5'd5:  begin lay = 5; kind = 0; neg = 1; end
      5'd6:  begin lay = 6; kind = 0; neg = 1; end
      5'd7:  begin lay = 1; kind = 1; neg = 0; end
      5'd8:  begin lay = 1; kind = 2; neg = 0; end
      5'd9:  begin lay = 1; kind = 2; neg = 1; end
      5'd10: begin lay = 3; kind = 0; neg = 0; end
      5'd11: begin lay = 4; kind = 0; neg = 0; end
      5'd12: begin lay = 4; kind = 1; neg = 1; end
      5'd13: begin lay = 4; kind = 1; neg = 0; end
      5'd14: begin lay = 5; kind = 0; neg = 0; end
      default: begin lay = 5; kind = 1; neg = 1; end
    endcase
    gi = '{default: '{default: 0}};
    go = '{default: 0};
    case (lay)
      1: begin
        gi[0] = '{1,2,0,0,0,0,0,0}; go[0] = 3;
        gi[1] = '{4,5,0,0,0,0,0,0}; go[1] = 6;
        gi[2] = '{9,10,0,0,0,0,0,0}; go[2] = 8;
        gi[3] = '{12,13,0,0,0,0,0,0}; go[3] = 11;
      end
      2: begin
        gi[0] = '{2,3,0,0,0,0,0,0}; go[0] = 1;
        gi[1] = '{5,6,0,0,0,0,0,0}; go[1] = 4;
        gi[2] = '{8,9,0,0,0,0,0,0}; go[2] = 10;
        gi[3] = '{11,12,0,0,0,0,0,0}; go[3] = 13;
      end
      3: begin
        gi[0][0] = 1;  go[0] = 2;
        gi[1][0] = 3;  go[1] = 4;
        gi[2][0] = 5;  go[2] = 6;
        gi[3][0] = 9;  go[3] = 8;
        gi[4][0] = 11; go[4] = 10;
        gi[5][0] = 13; go[5] = 12;
      end
      4: begin
        gi[0] = '{1,2,13,0,0,0,0,0}; go[0] = 12;
        gi[1] = '{3,4,5,0,0,0,0,0};  go[1] = 6;
        gi[2] = '{9,10,11,0,0,0,0,0}; go[2] = 8;
      end
      5: begin
        gi[0] = '{1,2,4,5,0,0,0,0};    go[0] = 6;
        gi[1] = '{9,10,12,13,0,0,0,0}; go[1] = 8;
      end
      default: begin
        gi[0] = '{1,2,3,4,5,6,11,12}; go[0] = 8;
      end
    endcase
    for (int g = 0; g < 6; g++) begin
      if (go[g] != 0) begin
        acc = (kind == 0);
        for (int k = 0; k < 8; k++) begin
          if (gi[g][k] != 0) begin
            if (kind == 0)      acc = acc & p[gi[g][k]-1];
            else if (kind == 1) acc = acc | p[gi[g][k]-1];
            else                acc = acc ^ p[gi[g][k]-1];
          end
        end
        if (neg) acc = ~acc;
        o[go[g]-1] = acc;
        d[go[g]-1] = 1'b1;
        l[g]       = acc;
      end
    end
  endtask

  task automatic check_sock(input int s, input logic [4:0] code, input string req);
    logic [13:0] eo, ed; logic [7:0] el;
    model(code, pin_in[s*14 +: 14], eo, ed, el);
    checks++;
    if (pin_out[s*14 +: 14] !== eo || pin_drv[s*14 +: 14] !== ed || led[s*8 +: 8] !== el) begin
      errors++;
      $display("FAIL %s socket %0d code %0d: out=%h drv=%h led=%h expected out=%h drv=%h led=%h",
               req, s, code, pin_out[s*14 +: 14], pin_drv[s*14 +: 14], led[s*8 +: 8], eo, ed, el);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic set_codes(input logic [4:0] c0, c1, c2, c3);
    @(negedge clk);
    sock_code = {c3, c2, c1, c0};
    @(posedge clk);
    #1;
    cur[0] = c0; cur[1] = c1; cur[2] = c2; cur[3] = c3;
  endtask

  function automatic logic [13:0] spread(input logic [11:0] v, input logic sup);
    logic [13:0] r;
    r = '0;
    r[5:0]  = v[5:0];
    r[12:7] = v[11:6];
    r[6]    = sup;
    r[13]   = ~sup;
    return r;
  endfunction

  initial begin
    logic [13:0] s0p, s1p, s2p, s3p;
    logic bi, a, b;
    logic [7:0] d_tab, bo_tab;
    rst_n = 1'b0;
    sock_code = {5'd4, 5'd8, 5'd2, 5'd7};
    pin_in = '1;
    repeat (3) @(posedge clk);
    #1;
    // R3: reset forces every socket empty
    for (int s = 0; s < 4; s++) check_sock(s, 5'd16, "R3");
    @(negedge clk);
    rst_n = 1'b1;
    sock_code = {5'd31, 5'd31, 5'd31, 5'd31};
    repeat (4) @(posedge clk);

    // R1 R5 R6 R7 R8: every supported code on every socket, all signal pin patterns
    for (int c = 0; c < 16; c++) begin
      set_codes(5'(c), 5'((c + 5) % 16), 5'((c + 10) % 16), 5'((c + 15) % 16));
      for (int v = 0; v < 4096; v++) begin
        for (int s = 0; s < 4; s++)
          pin_in[s*14 +: 14] = spread(12'(v) ^ 12'(s * 12'h5A5), v[0] ^ v[3]);
        #2;
        for (int s = 0; s < 4; s++) check_sock(s, cur[s], "R1 R5 R6 R7 R8");
        #3;
      end
    end

    // R4: codes 16..31 are empty whatever the pins do
    for (int c = 16; c < 32; c++) begin
      set_codes(5'(c), 5'd4, 5'(47 - c), 5'd9);
      for (int v = 0; v < 64; v++) begin
        pin_in = {4{spread(12'(v * 67), v[1])}};
        #2;
        check_sock(0, cur[0], "R4");
        check_sock(2, cur[2], "R4");
        check_sock(1, cur[1], "R1");
        #3;
      end
    end

    // R2: code change applies only after the capturing edge
    set_codes(5'd4, 5'd4, 5'd4, 5'd4);
    pin_in[13:0] = spread(12'b0000_0000_0001, 1'b0);  // pin1=1, pin2=0
    #1;
    check_bit(pin_out[2], 1'b0, "R2 AND before change");
    @(negedge clk);
    sock_code[4:0] = 5'd8;
    #1;
    check_bit(pin_out[2], 1'b0, "R2 old code holds before edge");
    @(posedge clk);
    #1;
    check_bit(pin_out[2], 1'b1, "R2 new code after edge");
    pin_in[1] = 1'b1;
    #0.5;
    check_bit(pin_out[2], 1'b0, "R2 pin path without clock");

    // R9: full subtractor, sockets XOR2, AND2, inverter, OR2
    set_codes(5'd8, 5'd4, 5'd2, 5'd7);
    d_tab  = 8'b1001_0110;
    bo_tab = 8'b1011_0010;
    for (int r = 0; r < 8; r++) begin
      {bi, a, b} = 3'(r);
      @(negedge clk);
      for (int it = 0; it < 4; it++) begin
        s0p = '0; s1p = '0; s2p = '0; s3p = '0;
        s0p[0] = a;  s0p[1] = b;  s0p[3] = pin_out[2]; s0p[4] = bi;
        s2p[0] = a;  s2p[2] = pin_out[2];
        s1p[0] = pin_out[28+1]; s1p[1] = b;
        s1p[3] = bi; s1p[4] = pin_out[28+3];
        s3p[0] = pin_out[14+2]; s3p[1] = pin_out[14+5];
        pin_in = {s3p, s2p, s1p, s0p};
        #0.5;
      end
      check_bit(led[1],  d_tab[r],  "R9 difference");
      check_bit(led[24], bo_tab[r], "R9 borrow out");
    end

    summary();
  end

endmodule